// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block is a single transmit DMA channel. Software places a ring of two-word descriptors in memory and tells the channel how far the ring has been filled. The channel reads each descriptor in turn. It then reads that descriptor's data buffer one 32-bit word at a time and sends the words out on a valid/ready stream. Each word can carry start-of-frame and end-of-frame markers. The channel never writes to the ring.

Software controls the channel through four 32-bit registers: control, ring base, last-posted offset and status. Control holds the enable, suspend and flush requests and the burst size. Status reports the next descriptor offset, a 4-bit state code, a 4-bit error code and the offset of the descriptor in progress. A sticky interrupt flag is raised when a descriptor that asks for it has been fully sent.

The memory side is a simple read port with one read outstanding at a time. A response may arrive any number of cycles after the request and may carry an error flag.

Top module: `txring_dma`

## Requirements
- R1: After reset the status register reads zero, `irq` is low, `tx_valid` is low and no memory read is issued.
- R2: A descriptor is two words at ring base plus offset. The first word is the control word and the second is the buffer address. The control word's bits [12:0] give the byte count, bit 28 marks end of ring, bit 29 requests an interrupt, bit 30 marks end of frame and bit 31 marks start of frame. The channel sends ceil(count/4) buffer words, in address order, starting at the buffer address.
- R3: The last-posted register (index 2, bits [11:0]) holds a descriptor offset. The channel processes descriptors, advancing its offset by 8 each time, until its offset equals the last-posted value. It then reports state 2 (idle).
- R4: After a descriptor with the end-of-ring bit set, the next offset is 0.
- R5: A stream word is held, unchanged, until `tx_ready` is high. `tx_sof` marks the first word of a start-of-frame descriptor. `tx_eof` marks the last word of an end-of-frame descriptor.
- R6: While control bit 0 (enable) is low, the state is 0 and no memory read is made. Disabling resets the offset to 0 and clears the error code.
- R7: Control bit 1 is the suspend request. When it is set, the current burst of 2^(N+4) bytes finishes, where N is control bits [20:18]. The channel then reports state 4 and issues no reads until the bit is cleared, after which it resumes where it stopped.
- R8: Writing control with bit 4 set is a one-shot flush. It drops the pending stream word and the rest of the work in progress, moves the offset to the last-posted value and returns to state 2. Bit 4 always reads back as 0.
- R9: A descriptor with a byte count of zero, or one with end-of-frame set while no frame is open and start-of-frame clear, sets error 1 and state 3 (stopped). The channel stays stopped until it is disabled.
- R10: An error response on a descriptor read sets error 4. An error response on a buffer read sets error 3. Both stop the channel (state 3).
- R11: `irq` is set when a descriptor with the interrupt bit finishes. It stays set until software writes the status register (index 3) with bit 0 set. If both happen in the same cycle, the set wins.
- R12: The status register (index 3) reads {active descriptor offset[31:20], error[19:16], state[15:12], offset[11:0]}. Register index 0 is control and index 1 is the ring base (bits [31:12]). Read data appears one cycle after `reg_addr`.
- R13: `mem_req` is a one-cycle pulse. At most one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response error |
| tx_valid | output | 1 | Stream word valid |
| tx_data | output | 32 | Stream word |
| tx_sof | output | 1 | First word of frame |
| tx_eof | output | 1 | Last word of frame |
| tx_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The main collision is a suspend boundary that falls on the last word of a descriptor. To provoke it, the bench posts a 16-byte buffer with a 16-byte burst size, stalls the stream while the first word is held and requests suspend, then releases the stream. The end of the burst and the end of the descriptor then land on the same word. The check passes when exactly four words leave, the offset has already advanced past the finished descriptor, the state reads 4 (suspended), and releasing the request returns the channel to idle without any further reads.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // reported state codes
  localparam logic [3:0] ST_DIS  = 4'd0;
  localparam logic [3:0] ST_ACT  = 4'd1;
  localparam logic [3:0] ST_IDLE = 4'd2;
  localparam logic [3:0] ST_STOP = 4'd3;
  localparam logic [3:0] ST_SUSP = 4'd4;

  // reported error codes
  localparam logic [3:0] ER_NONE = 4'd0;
  localparam logic [3:0] ER_PROT = 4'd1;
  localparam logic [3:0] ER_BUF  = 4'd3;
  localparam logic [3:0] ER_DESC = 4'd4;

  // control register bit positions
  localparam int CB_EN    = 0;
  localparam int CB_SUSP  = 1;
  localparam int CB_FLUSH = 4;
  localparam int CB_BURST = 18;

  // descriptor control word bit positions
  localparam int DB_EOT = 28;
  localparam int DB_IOC = 29;
  localparam int DB_EOF = 30;
  localparam int DB_SOF = 31;

  typedef enum logic [2:0] {
    PH_OFF, PH_IDLE, PH_CTRL, PH_ADDR, PH_DATA, PH_SUSP, PH_STOP
  } txr_phase_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFFW  = 12,
  parameter int BSELW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             ctl_en,
  output logic             ctl_susp,
  output logic             flush_pls,
  output logic [BSELW-1:0] ctl_burst,
  output logic [AW-1:0]    ring_base,
  output logic [OFFW-1:0]  last_off,
  input  logic [OFFW-1:0]  cur_off,
  input  logic [OFFW-1:0]  act_off,
  input  logic [3:0]       st_code,
  input  logic [3:0]       err_code,
  input  logic             irq_set,
  output logic             irq
);
  localparam int STW = 2 * OFFW + 8;

  logic [STW-1:0] status_w;
  assign status_w = {act_off, err_code, st_code, cur_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      ctl_susp  <= 1'b0;
      flush_pls <= 1'b0;
      ctl_burst <= '0;
      ring_base <= '0;
      last_off  <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flush_pls <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            ctl_en    <= reg_wdata[CB_EN];
            ctl_susp  <= reg_wdata[CB_SUSP];
            flush_pls <= reg_wdata[CB_FLUSH];
            ctl_burst <= reg_wdata[CB_BURST +: BSELW];
          end
          2'd1: ring_base <= {reg_wdata[AW-1:OFFW], {OFFW{1'b0}}};
          2'd2: last_off  <= reg_wdata[OFFW-1:0];
          default: ;
        endcase
      end
      if (irq_set) irq <= 1'b1;
      else if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) irq <= 1'b0;
      case (reg_addr)
        2'd0: reg_rdata <= (32'(ctl_burst) << CB_BURST) |
                           (32'(ctl_susp) << CB_SUSP) | 32'(ctl_en);
        2'd1: reg_rdata <= 32'(ring_base);
        2'd2: reg_rdata <= 32'(last_off);
        default: reg_rdata <= 32'(status_w);
      endcase
    end
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFFW  = 12,
  parameter int BCW   = 13,
  parameter int BSELW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             ctl_susp,
  input  logic             flush_pls,
  input  logic [BSELW-1:0] ctl_burst,
  input  logic [AW-1:0]    ring_base,
  input  logic [OFFW-1:0]  last_off,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  output logic             tx_sof,
  output logic             tx_eof,
  input  logic             tx_ready,
  output logic [OFFW-1:0]  cur_off,
  output logic [OFFW-1:0]  act_off,
  output logic [3:0]       st_code,
  output logic [3:0]       err_code,
  output logic             irq_set
);
  localparam int WCW = BCW - 1;             // word counter width
  localparam int BLW = 9;                   // up to 256 words per burst
  localparam logic [OFFW-1:0] DSTEP = OFFW'(8);

  txr_phase_e ph;
  logic outst, own, in_frame, first_w, resume_data;
  logic [BCW-1:0] d_bc;
  logic d_eot, d_ioc, d_eof, d_sof;
  logic [AW-1:0] baddr;
  logic [WCW-1:0] wleft;
  logic [BLW-1:0] bleft, bwords;
  logic [BSELW-1:0] bsel;
  logic issue, got;
  logic [BCW-1:0] rbc;

  assign bsel   = (ctl_burst > BSELW'(6)) ? BSELW'(6) : ctl_burst;
  assign bwords = BLW'(1) << ({1'b0, bsel} + 4'd2);
  assign rbc    = mem_rdata[BCW-1:0];
  assign got    = mem_rvalid && own;
  assign issue  = !outst && (ph == PH_CTRL || ph == PH_ADDR ||
                             (ph == PH_DATA && !tx_valid));

  always_comb begin
    case (ph)
      PH_OFF:  st_code = ST_DIS;
      PH_IDLE: st_code = ST_IDLE;
      PH_SUSP: st_code = ST_SUSP;
      PH_STOP: st_code = ST_STOP;
      default: st_code = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OFF; outst <= 1'b0; own <= 1'b0; in_frame <= 1'b0;
      first_w <= 1'b0; resume_data <= 1'b0; mem_req <= 1'b0; mem_addr <= '0;
      tx_valid <= 1'b0; tx_data <= '0; tx_sof <= 1'b0; tx_eof <= 1'b0;
      cur_off <= '0; act_off <= '0; err_code <= ER_NONE; irq_set <= 1'b0;
      d_bc <= '0; d_eot <= 1'b0; d_ioc <= 1'b0; d_eof <= 1'b0; d_sof <= 1'b0;
      baddr <= '0; wleft <= '0; bleft <= '0;
    end else begin
      mem_req <= 1'b0;
      irq_set <= 1'b0;
      if (mem_rvalid) begin outst <= 1'b0; own <= 1'b0; end
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (issue && ctl_en && !flush_pls) begin
        mem_req <= 1'b1; outst <= 1'b1; own <= 1'b1;
        case (ph)
          PH_CTRL: mem_addr <= ring_base | AW'(cur_off);
          PH_ADDR: mem_addr <= ring_base | AW'(cur_off + OFFW'(4));
          default: mem_addr <= baddr;
        endcase
      end
      if (!ctl_en) begin
        ph <= PH_OFF; cur_off <= '0; act_off <= '0; err_code <= ER_NONE;
        in_frame <= 1'b0; tx_valid <= 1'b0; own <= 1'b0;
      end else if (flush_pls && ph != PH_STOP && ph != PH_OFF) begin
        ph <= PH_IDLE; cur_off <= last_off; in_frame <= 1'b0;
        tx_valid <= 1'b0; own <= 1'b0;
      end else begin
        case (ph)
          PH_OFF: ph <= PH_IDLE;
          PH_IDLE: begin
            if (ctl_susp) begin ph <= PH_SUSP; resume_data <= 1'b0; end
            else if (cur_off != last_off) ph <= PH_CTRL;
          end
          PH_CTRL: if (got) begin
            act_off <= cur_off;
            d_bc <= rbc; d_eot <= mem_rdata[DB_EOT]; d_ioc <= mem_rdata[DB_IOC];
            d_eof <= mem_rdata[DB_EOF]; d_sof <= mem_rdata[DB_SOF];
            if (mem_err) begin ph <= PH_STOP; err_code <= ER_DESC; end
            else if (rbc == '0 ||
                     (mem_rdata[DB_EOF] && !mem_rdata[DB_SOF] && !in_frame)) begin
              ph <= PH_STOP; err_code <= ER_PROT;
            end else ph <= PH_ADDR;
          end
          PH_ADDR: if (got) begin
            if (mem_err) begin ph <= PH_STOP; err_code <= ER_DESC; end
            else begin
              baddr   <= mem_rdata;
              wleft   <= WCW'(({1'b0, d_bc} + (BCW+1)'(3)) >> 2);
              bleft   <= bwords;
              first_w <= 1'b1;
              ph      <= PH_DATA;
            end
          end
          PH_DATA: if (got) begin
            if (mem_err) begin ph <= PH_STOP; err_code <= ER_BUF; end
            else begin
              tx_valid <= 1'b1;
              tx_data  <= mem_rdata;
              tx_sof   <= d_sof && first_w;
              tx_eof   <= d_eof && (wleft == WCW'(1));
              first_w  <= 1'b0;
              baddr    <= baddr + AW'(4);
              wleft    <= wleft - WCW'(1);
              if (wleft == WCW'(1)) begin
                irq_set  <= d_ioc;
                in_frame <= d_eof ? 1'b0 : (in_frame | d_sof);
                cur_off  <= d_eot ? '0 : cur_off + DSTEP;
                ph       <= PH_IDLE;
              end else if (bleft == BLW'(1)) begin
                bleft <= bwords;
                if (ctl_susp) begin ph <= PH_SUSP; resume_data <= 1'b1; end
              end else bleft <= bleft - BLW'(1);
            end
          end
          PH_SUSP: if (!ctl_susp) ph <= resume_data ? PH_DATA : PH_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFFW  = 12,
  parameter int BCW   = 13,
  parameter int BSELW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          tx_ready,
  output logic          irq
);
  logic ctl_en, ctl_susp, flush_pls, irq_set;
  logic [BSELW-1:0] ctl_burst;
  logic [AW-1:0] ring_base;
  logic [OFFW-1:0] last_off, cur_off, act_off;
  logic [3:0] st_code, err_code;

  txr_regs #(.AW(AW), .OFFW(OFFW), .BSELW(BSELW)) u_regs (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ctl_en, .ctl_susp, .flush_pls, .ctl_burst, .ring_base, .last_off,
    .cur_off, .act_off, .st_code, .err_code, .irq_set, .irq
  );

  txr_seq #(.AW(AW), .OFFW(OFFW), .BCW(BCW), .BSELW(BSELW)) u_seq (
    .clk, .rst, .ctl_en, .ctl_susp, .flush_pls, .ctl_burst, .ring_base,
    .last_off, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata, .mem_err,
    .tx_valid, .tx_data, .tx_sof, .tx_eof, .tx_ready, .cur_off, .act_off,
    .st_code, .err_code, .irq_set
  );
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        irq,
  input logic [3:0]  st_code
);
  logic ctl_wr;
  assign ctl_wr = reg_wr && reg_addr == 2'd0;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R13

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !ctl_wr && !$past(ctl_wr))
      |=> (tx_valid && $stable(tx_data))); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> irq); // R11

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_code == 4'd3 && !ctl_wr && !$past(ctl_wr)) |=> st_code == 4'd3); // R9

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_code == 4'd0 && $past(st_code) == 4'd0) |-> !mem_req); // R6

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_code == 4'd4 && $past(st_code) == 4'd4) |-> !mem_req); // R7
endmodule

bind txring_dma txring_dma_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq), .st_code(st_code)
);

// File: tb/txring_dma_tb.sv
module txring_dma_tb;
  localparam logic [31:0] RB = 32'h1000;
  // {byte count[37:25], end-of-ring[24], expected words[23:12], expected next offset[11:0]}
  localparam logic [37:0] VEC [6] = '{
    {13'd4,   1'b0, 12'd1,  12'd8},
    {13'd5,   1'b0, 12'd2,  12'd16},
    {13'd64,  1'b0, 12'd16, 12'd24},
    {13'd13,  1'b1, 12'd4,  12'd0},
    {13'd1,   1'b0, 12'd1,  12'd8},
    {13'd200, 1'b0, 12'd50, 12'd16}
  };
  localparam logic [31:0] F_SOF = 32'h8000_0000, F_EOF = 32'h4000_0000;
  localparam logic [31:0] F_IOC = 32'h2000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic tx_valid, tx_sof, tx_eof, tx_ready = 1'b1, irq;
  logic [31:0] tx_data;

  logic [31:0] mem [4096];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int nchk = 0, nfail = 0;
  int rx_cnt = 0, rx_bad = 0, sofc = 0, eofc = 0, nreq = 0, exp_idx = 0;
  logic first_sof = 1'b0, last_eof = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  txring_dma u_dut (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .mem_req,
    .mem_addr, .mem_rvalid, .mem_rdata, .mem_err, .tx_valid, .tx_data,
    .tx_sof, .tx_eof, .tx_ready, .irq
  );

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[13:2]];
    mem_err    <= mem_req && (mem_addr == err_addr);
  end

  always @(negedge clk) if (!rst) begin
    if (mem_req) nreq++;
    if (tx_valid && tx_ready) begin
      if (tx_data !== mem[exp_idx + rx_cnt]) rx_bad++;
      if (rx_cnt == 0) first_sof = tx_sof;
      last_eof = tx_eof;
      rx_cnt++;
      if (tx_sof) sofc++;
      if (tx_eof) eofc++;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic wait_st(input logic [3:0] code, input logic [11:0] cur, output logic [31:0] s);
    for (int k = 0; k < 400; k++) begin
      rd(2'd3, s);
      if (s[15:12] == code && s[11:0] == cur) break;
    end
  endtask

  task automatic post(input logic [11:0] off, input logic [31:0] ctl, input logic [31:0] b);
    mem[(RB + 32'(off)) >> 2]       = ctl;
    mem[((RB + 32'(off)) >> 2) + 1] = b;
  endtask

  task automatic clr_rx(input logic [31:0] b);
    exp_idx = int'(b >> 2); rx_cnt = 0; rx_bad = 0; sofc = 0; eofc = 0;
  endtask

  task automatic restart(input logic [2:0] bl);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1 | (32'(bl) << 18));
  endtask

  task automatic wait_txv();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (tx_valid) break;
    end
  endtask

  initial begin
    logic [31:0] s;
    logic [11:0] cur;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h5A00_0000 + 32'(i);
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // reset state
    rd(2'd3, s);
    chk("R1 status after reset", s, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);

    // disabled: posting has no effect
    wr(2'd1, RB);
    post(12'd0, F_SOF | F_EOF | 32'd4, 32'h3C00);
    wr(2'd2, 32'd8);
    repeat (20) @(posedge clk);
    rd(2'd3, s);
    chk("R6 state while disabled", {28'b0, s[15:12]}, 32'd0);
    chk("R6 no reads while disabled", 32'(nreq), 32'd0);
    wr(2'd2, 32'd0);
    rd(2'd1, s);
    chk("R12 ring base readback", s, RB);

    // table of single-descriptor frames, burst 64 bytes
    restart(3'd2);
    cur = 12'd0;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] b;
      logic [11:0] nxt;
      b = 32'h2000 + 32'(i) * 32'h400;
      nxt = VEC[i][11:0];
      clr_rx(b);
      post(cur, F_SOF | F_EOF | (32'(VEC[i][24]) << 28) | 32'(VEC[i][37:25]), b);
      wr(2'd2, 32'(nxt));
      wait_st(4'd2, nxt, s);
      repeat (4) @(posedge clk);
      chk(VEC[i][24] ? "R4 wrap offset" : "R3 idle offset", {20'b0, s[11:0]}, 32'(nxt));
      chk("R2 word count", 32'(rx_cnt), 32'(VEC[i][23:12]));
      chk("R2 data order", 32'(rx_bad), 32'd0);
      chk("R5 sof/eof marks", {16'(sofc), 16'(eofc)}, {16'd1, 16'd1});
      chk("R12 active descriptor", {20'b0, s[31:20]}, 32'(cur));
      cur = nxt;
    end
    chk("R11 no irq without flag", {31'b0, irq}, 32'h0);

    // interrupt: set on flagged completion, sticky, write-one clear
    restart(3'd0);
    clr_rx(32'h3C00);
    post(12'd0, F_SOF | F_EOF | F_IOC | 32'd4, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_st(4'd2, 12'd8, s);
    chk("R11 irq set", {31'b0, irq}, 32'h1);
    repeat (10) @(posedge clk);
    chk("R11 irq sticky", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h1);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);

    // two descriptors forming one frame, posted together
    restart(3'd0);
    clr_rx(32'h3800);
    post(12'd0, F_SOF | 32'd8, 32'h3800);
    post(12'd8, F_EOF | 32'd8, 32'h3808);
    wr(2'd2, 32'd16);
    wait_st(4'd2, 12'd16, s);
    repeat (4) @(posedge clk);
    chk("R3 two-descriptor words", 32'(rx_cnt), 32'd4);
    chk("R5 frame marks", {16'(sofc), 16'(eofc)}, {16'd1, 16'd1});
    chk("R5 first sof last eof", {30'b0, first_sof, last_eof}, 32'h3);
    chk("R2 frame data", 32'(rx_bad), 32'd0);

    // suspend finishes the current burst: 16 bytes then 32 bytes
    for (int bl = 0; bl < 2; bl++) begin
      restart(3'(bl));
      tx_ready = 1'b0;
      clr_rx(32'h3C00);
      post(12'd0, F_SOF | F_EOF | 32'd128, 32'h3C00);
      wr(2'd2, 32'd8);
      wait_txv();
      wr(2'd0, 32'h3 | (32'(bl) << 18));
      @(posedge clk); #1 tx_ready = 1'b1;
      repeat (80) @(posedge clk);
      rd(2'd3, s);
      chk("R7 words before suspend", 32'(rx_cnt), (bl == 0) ? 32'd4 : 32'd8);
      chk("R7 suspend state", {28'b0, s[15:12]}, 32'd4);
      wr(2'd0, 32'h1 | (32'(bl) << 18));
      wait_st(4'd2, 12'd8, s);
      repeat (4) @(posedge clk);
      chk("R7 resumed total words", 32'(rx_cnt), 32'd32);
      chk("R7 resumed data", 32'(rx_bad), 32'd0);
    end

    // burst end and descriptor end on the same word, with suspend pending
    restart(3'd0);
    tx_ready = 1'b0;
    clr_rx(32'h3C00);
    post(12'd0, F_SOF | F_EOF | 32'd16, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_txv();
    wr(2'd0, 32'h3);
    @(posedge clk); #1 tx_ready = 1'b1;
    repeat (40) @(posedge clk);
    rd(2'd3, s);
    chk("R7 collide words", 32'(rx_cnt), 32'd4);
    chk("R7 collide state/offset", {16'b0, s[15:0]}, 32'h4008);
    nreq = 0;
    wr(2'd0, 32'h1);
    wait_st(4'd2, 12'd8, s);
    chk("R7 collide release idle", {28'b0, s[15:12]}, 32'd2);
    chk("R13 no reads after release", 32'(nreq), 32'd0);

    // flush drops the held word and the rest of the buffer
    restart(3'd0);
    tx_ready = 1'b0;
    clr_rx(32'h3C00);
    post(12'd0, F_SOF | F_EOF | 32'd64, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_txv();
    wr(2'd0, 32'h11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 held word dropped", {31'b0, tx_valid}, 32'h0);
    rd(2'd3, s);
    chk("R8 flush state/offset", {16'b0, s[15:0]}, 32'h2008);
    rd(2'd0, s);
    chk("R8 flush bit reads zero", s, 32'h1);
    #1 tx_ready = 1'b1;
    repeat (30) @(posedge clk);
    chk("R8 nothing sent after flush", 32'(rx_cnt), 32'd0);

    // zero byte count: protocol error, stays stopped
    restart(3'd0);
    post(12'd0, F_SOF | F_EOF, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_st(4'd3, 12'd0, s);
    chk("R9 zero count error", {28'b0, s[19:16]}, 32'd1);
    repeat (20) @(posedge clk);
    rd(2'd3, s);
    chk("R9 stays stopped", {28'b0, s[15:12]}, 32'd3);
    restart(3'd0);
    rd(2'd3, s);
    chk("R6 re-enable clears error", {16'b0, s[19:0]}, 32'h02000);

    // end of frame with no frame open
    post(12'd0, F_EOF | 32'd4, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_st(4'd3, 12'd0, s);
    chk("R9 orphan eof error", {28'b0, s[19:16]}, 32'd1);

    // bus error on descriptor read
    restart(3'd0);
    err_addr = RB;
    post(12'd0, F_SOF | F_EOF | 32'd4, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_st(4'd3, 12'd0, s);
    chk("R10 descriptor bus error", {28'b0, s[19:16]}, 32'd4);

    // bus error on the third buffer word
    restart(3'd0);
    err_addr = 32'h3C08;
    clr_rx(32'h3C00);
    post(12'd0, F_SOF | F_EOF | 32'd32, 32'h3C00);
    wr(2'd2, 32'd8);
    wait_st(4'd3, 12'd0, s);
    repeat (4) @(posedge clk);
    chk("R10 buffer bus error", {28'b0, s[19:16]}, 32'd3);
    chk("R10 words before error", 32'(rx_cnt), 32'd2);
    err_addr = 32'hFFFF_FFFF;

    done = 1'b1;
    report();
  end
endmodule